// File: doc/BRIEF.md
# UV-Erasable Byte-Wide PROM Model

This block is a synthesizable, clocked model of a byte-wide read-only memory that is erased by light and written one byte at a time. The pins of the part appear as plain synchronous inputs: an address bus, an active-low chip select that doubles as the program strobe, an active-low output enable, and two flags. One flag says the programming voltage is on the output-enable pin. The other says a high voltage is on the identification address line. The three-state data bus is split into a data input, a data output and a drive-enable flag. Erase is a single synchronous input that sets every stored bit to 1 in one cycle.

The block decodes the pin levels into one of six modes and reports that mode on a status output. In the two reading modes it drives either the stored byte or a two-byte identification signature. It writes a byte only at the end of a genuine low pulse on the chip select, taken while the programming voltage is present. A write can only clear bits. The depth is a parameter: the nominal size is 64K bytes, and the default is smaller so that simulation stays small. There is no streaming interface, because every pin is a level-sensitive control or data line, so all ports stay plain.

Top module: `uvprom_ctrl`

## Requirements
- R1: `mode_o` encodes the decoded mode as 0 read, 1 output disable, 2 standby, 3 program, 4 program verify and 5 program inhibit. The decode order is as follows. If `vpp_hi_i` is set, the mode is 5 when `ce_n_i` is high and 3 when it is low. Otherwise the mode is 2 when `ce_n_i` is high. Otherwise the mode is 1 when `oe_n_i` is high. Otherwise the mode is 4 when a verify session is open and 0 when it is not.
- R2: `data_oe_o` is 1 only in modes 0 and 4, and is 0 in every other mode.
- R3: A one-cycle `erase_i` makes every byte read back 0xFF from the next cycle on.
- R4: A write stores the old byte AND the presented byte. A 1 in the presented data leaves that bit as it was.
- R5: A write commits on the clock edge that first sees `ce_n_i` high after a low pulse. That pulse must have started while `vpp_hi_i` was set, and `vpp_hi_i` must still be set at the commit. The address and data used are those present in the last cycle that `ce_n_i` was low.
- R6: No write happens for a chip select that is already low when reset ends, or that goes low before `vpp_hi_i` rises.
- R7: If `vpp_hi_i` is removed while the pulse is still low, the pulse is abandoned and nothing is written.
- R8: While `ce_n_i` stays high with `vpp_hi_i` set, the array does not change.
- R9: With `idhv_i` set in a driving mode, `data_o` is 0x8F when address bit 0 is 0 and 0x85 when it is 1. All other address bits are ignored.
- R10: A commit opens a verify session. A cycle in standby or an erase closes it. While the session is open, both enables low with no programming voltage gives mode 4 and drives the stored byte.
- R11: If `erase_i` and a commit fall on the same edge, the erase wins. The byte reads 0xFF afterwards and no verify session is opened.
- R12: While `rst_n` is low, nothing is armed and no session is open. The mode follows the pins alone, and a driving mode is never entered because of a stale session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state (not of the array) |
| addr_i | input | AW | Byte address |
| ce_n_i | input | 1 | Active-low chip select and program strobe |
| oe_n_i | input | 1 | Active-low output enable |
| vpp_hi_i | input | 1 | Programming voltage present on the output-enable pin |
| idhv_i | input | 1 | High voltage on the identification address line |
| erase_i | input | 1 | Synchronous erase of the whole array to ones |
| data_i | input | DW | Byte presented for programming |
| data_o | output | DW | Byte driven onto the bus; don't-care when not driven |
| data_oe_o | output | 1 | Bus drive enable |
| mode_o | output | 3 | Decoded mode code |

## Verification
Two functions can fall on the same clock edge: an erase and the commit of a program pulse. The bench raises the chip select and asserts `erase_i` at the same negative edge, so that both are seen at one rising edge. It then judges the outcome at the ports. The target byte must read 0xFF, and re-entering the reading condition must report mode 0 rather than verify. A second overlap, a commit against an open verify session, is judged by reading mode 4 straight after the pulse, then mode 0 after a standby cycle.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_OUTDIS  = 3'd1,
    MD_STANDBY = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_VERIFY  = 3'd4,
    MD_INHIBIT = 3'd5
  } uvprom_mode_e;

  function automatic logic mode_drives(uvprom_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY);
  endfunction

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
  import uvprom_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic         vpp_hi,
  input  logic         commit,
  input  logic         erase,
  output uvprom_mode_e mode
);

  logic sess_q;

  // verify session: opened by a commit, closed by standby or erase
  always_ff @(posedge clk) begin
    if (!rst_n)                sess_q <= 1'b0;
    else if (erase)            sess_q <= 1'b0;
    else if (commit)           sess_q <= 1'b1;
    else if (ce_n && !vpp_hi)  sess_q <= 1'b0;
  end

  always_comb begin
    if (vpp_hi)      mode = ce_n ? MD_INHIBIT : MD_PROGRAM;
    else if (ce_n)   mode = MD_STANDBY;
    else if (oe_n)   mode = MD_OUTDIS;
    else             mode = sess_q ? MD_VERIFY : MD_READ;
  end

  // R10: a standby cycle leaves no session behind
  a_r10_standby_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n && !vpp_hi) |-> (mode != MD_VERIFY));

  // R12: during reset the session is closed
  a_r12_reset_no_sess: assert property (@(posedge clk)
    !rst_n |=> !sess_q);

endmodule

// File: rtl/uvprom_prog_seq.sv
module uvprom_prog_seq #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          vpp_hi,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);

  logic ce_q;    // reset low so a select already low after reset shows no edge
  logic armed_q;
  logic fall, rise;

  assign fall = ce_q && !ce_n;
  assign rise = !ce_q && ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (fall && vpp_hi)                  armed_q <= 1'b1;
      else if (armed_q && (!vpp_hi || rise)) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!ce_n && vpp_hi && (armed_q || fall)) begin
      c_addr <= addr;
      c_data <= din;
    end
  end

  assign commit = armed_q && rise && vpp_hi;

  // R6: no commit while the strobe is low
  a_r6_no_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !commit);

  // R7: no commit without programming voltage
  a_r7_no_commit_novpp: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |-> !commit);

  // R12: nothing armed right after reset
  a_r12_reset_disarm: assert property (@(posedge clk)
    !rst_n |=> !armed_q);

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_byte;

  assign old_byte = mem[wr_addr];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_addr] <= old_byte & wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R3: erase leaves both ends of the array at all ones
  a_r3_erase_ones: assert property (@(posedge clk)
    erase |=> (mem[0] == '1) && (mem[DEPTH-1] == '1));

  // R4: a write never raises a bit
  a_r4_bits_fall_only: assert property (@(posedge clk)
    (wr_en && !erase) |=> ((mem[$past(wr_addr)] & ~$past(old_byte)) == '0));

endmodule

// File: rtl/uvprom_sig.sv
module uvprom_sig #(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] MFR_CODE = 8'h8F,
  parameter logic [DW-1:0] DEV_CODE = 8'h85
) (
  input  logic          sel,
  output logic [DW-1:0] code
);

  assign code = sel ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/uvprom_ctrl.sv
module uvprom_ctrl
  import uvprom_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          vpp_hi_i,
  input  logic          idhv_i,
  input  logic          erase_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [2:0]    mode_o
);

  uvprom_mode_e  mode;
  logic          commit;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] sig_code;

  uvprom_prog_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_i), .vpp_hi(vpp_hi_i),
    .addr(addr_i), .din(data_i),
    .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  uvprom_mode_dec u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_i), .oe_n(oe_n_i),
    .vpp_hi(vpp_hi_i), .commit(commit), .erase(erase_i), .mode(mode)
  );

  uvprom_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .erase(erase_i), .wr_en(commit),
    .wr_addr(c_addr), .wr_data(c_data),
    .rd_addr(addr_i), .rd_data(rd_data)
  );

  uvprom_sig #(.DW(DW)) u_sig (
    .sel(addr_i[0]), .code(sig_code)
  );

  assign data_oe_o = mode_drives(mode);
  assign data_o    = idhv_i ? sig_code : rd_data;
  assign mode_o    = mode;

  // R2: the bus floats in standby, output disable and all programming modes
  a_r2_float_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> !data_oe_o);
  a_r2_float_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n_i && !vpp_hi_i) |-> !data_oe_o);
  a_r2_float_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi_i |-> !data_oe_o);

  // R9: only the two signature bytes appear under the identification voltage
  a_r9_sig_values: assert property (@(posedge clk) disable iff (!rst_n)
    (idhv_i && data_oe_o) |-> ((data_o == 8'h8F) || (data_o == 8'h85)));

endmodule

// File: tb/test_uvprom_ctrl.sv
module test_uvprom_ctrl;

  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, oe_n, vpp, idhv, erase;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          doe;
  logic [2:0]    mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  uvprom_ctrl #(.AW(AW), .DW(DW)) i_uvprom_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .vpp_hi_i(vpp), .idhv_i(idhv), .erase_i(erase), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .mode_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic c, input logic o, input logic v);
    ce_n = c; oe_n = o; vpp = v;
  endtask

  // program pulse; if late_change, addr/data change on the rising strobe
  task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic late_change, input logic with_erase);
    nedge(1); set_pins(1'b1, 1'b1, 1'b1); addr = a; din = d;
    nedge(1); ce_n = 1'b0;
    nedge(2); ce_n = 1'b1;
    if (late_change) begin addr = a ^ 10'h001; din = 8'h00; end
    if (with_erase) erase = 1'b1;
    nedge(1); erase = 1'b0; vpp = 1'b0;
  endtask

  // plain read through standby, so no session is open
  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    nedge(1); set_pins(1'b1, 1'b1, 1'b0);
    nedge(1); set_pins(1'b0, 1'b0, 1'b0); addr = a;
    #1 d = dout;
  endtask

  task automatic t_reset_held_low;
    logic [DW-1:0] v;
    rst_n = 1'b0; set_pins(1'b0, 1'b1, 1'b1); idhv = 1'b0; erase = 1'b1;
    addr = 10'h010; din = 8'h00;
    nedge(1); erase = 1'b0;
    nedge(1);
    chk("R12 reset mode", int'(mode), 3);
    chk("R12 reset no drive", int'(doe), 0);
    rst_n = 1'b1;
    nedge(3); ce_n = 1'b1;
    nedge(1); vpp = 1'b0;
    rd(10'h010, v);
    chk("R6 held low from reset", int'(v), 8'hFF);
    // select low before voltage rises
    nedge(1); set_pins(1'b0, 1'b1, 1'b0); addr = 10'h011;
    nedge(1); vpp = 1'b1;
    nedge(2); ce_n = 1'b1;
    nedge(1); vpp = 1'b0;
    rd(10'h011, v);
    chk("R6 low before voltage", int'(v), 8'hFF);
  endtask

  task automatic t_decode;
    nedge(1); set_pins(1'b1, 1'b1, 1'b0); #1 chk("R1 standby both high", int'(mode), 2);
    nedge(1); set_pins(1'b1, 1'b0, 1'b0); #1 chk("R1 standby", int'(mode), 2);
    chk("R2 standby float", int'(doe), 0);
    nedge(1); set_pins(1'b0, 1'b1, 1'b0); #1 chk("R1 outdis", int'(mode), 1);
    chk("R2 outdis float", int'(doe), 0);
    nedge(1); set_pins(1'b0, 1'b0, 1'b0); #1 chk("R1 read", int'(mode), 0);
    chk("R2 read drives", int'(doe), 1);
    nedge(1); set_pins(1'b1, 1'b1, 1'b1); #1 chk("R1 inhibit", int'(mode), 5);
    chk("R2 inhibit float", int'(doe), 0);
    nedge(1); set_pins(1'b1, 1'b0, 1'b1); #1 chk("R8 inhibit", int'(mode), 5);
    nedge(1); set_pins(1'b0, 1'b1, 1'b1); #1 chk("R1 program", int'(mode), 3);
    chk("R2 program float", int'(doe), 0);
    nedge(1); set_pins(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_and_write;
    logic [DW-1:0] v;
    pulse(10'h005, 8'hA5, 1'b0, 1'b0); rd(10'h005, v); chk("R4 first", int'(v), 8'hA5);
    pulse(10'h005, 8'h0F, 1'b0, 1'b0); rd(10'h005, v); chk("R4 and", int'(v), 8'h05);
    pulse(10'h005, 8'hFF, 1'b0, 1'b0); rd(10'h005, v); chk("R4 ones keep", int'(v), 8'h05);
  endtask

  task automatic t_sampled;
    logic [DW-1:0] v;
    pulse(10'h020, 8'h3C, 1'b1, 1'b0);
    rd(10'h020, v); chk("R5 sampled data", int'(v), 8'h3C);
    rd(10'h021, v); chk("R5 late addr unused", int'(v), 8'hFF);
  endtask

  task automatic t_abort_inhibit;
    logic [DW-1:0] v;
    nedge(1); set_pins(1'b1, 1'b1, 1'b1); addr = 10'h030; din = 8'h00;
    nedge(1); ce_n = 1'b0;
    nedge(1); vpp = 1'b0;
    nedge(1); vpp = 1'b1;
    nedge(1); ce_n = 1'b1;
    nedge(1); vpp = 1'b0;
    rd(10'h030, v); chk("R7 abort", int'(v), 8'hFF);
    nedge(1); set_pins(1'b1, 1'b1, 1'b1); addr = 10'h031; din = 8'h00;
    nedge(4); vpp = 1'b0;
    rd(10'h031, v); chk("R8 inhibit no write", int'(v), 8'hFF);
  endtask

  task automatic t_signature;
    nedge(1); set_pins(1'b0, 1'b0, 1'b0); idhv = 1'b1; addr = 10'h000;
    #1 chk("R9 maker byte", int'(dout), 8'h8F);
    chk("R9 driven", int'(doe), 1);
    nedge(1); addr = 10'h001; #1 chk("R9 device byte", int'(dout), 8'h85);
    nedge(1); addr = 10'h3FE; #1 chk("R9 other bits ignored", int'(dout), 8'h8F);
    nedge(1); oe_n = 1'b1; #1 chk("R2 sig float", int'(doe), 0);
    nedge(1); idhv = 1'b0; set_pins(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_verify;
    pulse(10'h040, 8'h5A, 1'b0, 1'b0);
    set_pins(1'b0, 1'b0, 1'b0); addr = 10'h040;
    #1 chk("R10 verify mode", int'(mode), 4);
    chk("R10 verify data", int'(dout), 8'h5A);
    nedge(1); set_pins(1'b1, 1'b1, 1'b0);
    nedge(1); set_pins(1'b0, 1'b0, 1'b0);
    #1 chk("R10 closed by standby", int'(mode), 0);
  endtask

  task automatic t_erase_collide;
    logic [DW-1:0] v;
    pulse(10'h050, 8'h00, 1'b0, 1'b1);
    set_pins(1'b0, 1'b0, 1'b0); addr = 10'h050;
    #1 chk("R11 no session", int'(mode), 0);
    chk("R11 erase wins", int'(dout), 8'hFF);
    nedge(1); erase = 1'b1;
    nedge(1); erase = 1'b0;
    rd(10'h005, v); chk("R3 erased a", int'(v), 8'hFF);
    rd(10'h020, v); chk("R3 erased b", int'(v), 8'hFF);
  endtask

  initial begin
    t_reset_held_low();
    t_decode();
    t_and_write();
    t_sampled();
    t_abort_inhibit();
    t_signature();
    t_verify();
    t_erase_collide();
    nedge(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule